// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 40-bit Guard-Bit Accumulator

This unit multiplies two 16-bit operands and folds the product into a 40-bit accumulator in a single clock. Each operand has its own signedness select, so the unit can form signed, unsigned or mixed-sign products. Before the product is used, it is widened to 40 bits. By default it is also shifted left by one place to suit fractional (1.15) arithmetic. An integer mode bit leaves the product unshifted.

Three operations are available: plain multiply, which replaces the accumulator contents; multiply-add; and multiply-subtract. The result goes either to the accumulator or to a 16-bit feedback register, which receives the middle word of the result. The accumulator is exposed as three sections: a low word, a middle word and an 8-bit guard section. Each section can be loaded on its own from a 16-bit bus.

Top module: `mac40_unit`

## Requirements
- R1: With `a_signed`/`b_signed` at 1 an operand is two's complement, at 0 unsigned. The 32-bit product is sign-extended to 40 bits when either operand is signed, and zero-extended when both are unsigned.
- R2: With `int_mode`=0 the 40-bit extended product is shifted left by one bit, so bit 39 is dropped and bit 0 is zero. With `int_mode`=1 no shift is applied.
- R3: `op_sel`=2'b00 (and 2'b11) is a plain multiply: the result is the product, and the previous accumulator value is discarded.
- R4: `op_sel`=2'b01 gives the result accumulator + product, modulo 2^40.
- R5: `op_sel`=2'b10 gives the result accumulator − product, modulo 2^40.
- R6: With `op_valid`=1 and `to_fb`=0, the result appears on `{acc_hi,acc_mid,acc_lo}` after the next rising edge, and `fb_out` is unchanged.
- R7: With `op_valid`=1 and `to_fb`=1, `fb_out` takes result bits 31:16 after the next rising edge. The accumulator is not changed by the operation.
- R8: With `ld_en`=1, `ld_sel`=0 loads the low word, 1 loads the middle word, and 2 loads the guard section from `ld_data[7:0]`. The other sections are untouched. `ld_sel`=3 changes nothing.
- R9: If a load and an operation that targets the accumulator fall in the same cycle, the operation wins and the load is lost. If the operation targets the feedback register, both take effect, and the result is computed from the accumulator value before the load.
- R10: Reset (`rst_n`=0) clears the accumulator and the feedback register. With `op_valid`=0 and `ld_en`=0 the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform an operation this cycle |
| op_sel | input | 2 | 00/11 multiply, 01 multiply-add, 10 multiply-subtract |
| a_in | input | 16 | X operand |
| b_in | input | 16 | Y operand |
| a_signed | input | 1 | X operand is two's complement |
| b_signed | input | 1 | Y operand is two's complement |
| int_mode | input | 1 | 1 suppresses the fractional left shift |
| to_fb | input | 1 | 1 sends the result to the feedback register |
| ld_en | input | 1 | Load one accumulator section |
| ld_sel | input | 2 | Section to load: 0 low, 1 middle, 2 guard |
| ld_data | input | 16 | Load data |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| acc_mid | output | 16 | Accumulator bits 31:16 |
| acc_hi | output | 8 | Accumulator bits 39:32 |
| fb_out | output | 16 | Feedback register |

## Verification
A section load and an arithmetic operation can arrive in the same cycle. Which one prevails depends on where the result is sent. The bench provokes this collision in two directed cases, one for each destination. Its random phase asserts `ld_en` and `op_valid` independently, so the collision recurs many times. In every case a bench model that computes the result from the pre-load accumulator judges both the accumulator sections and the feedback register.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [1:0] {
    MOP_MUL  = 2'b00,
    MOP_ADD  = 2'b01,
    MOP_SUB  = 2'b10,
    MOP_MUL2 = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  input  logic            a_sgn_i,
  input  logic            b_sgn_i,
  input  logic            int_i,
  output logic [ACCW-1:0] prod_o
);
  localparam int PW = 2 * OPW;
  localparam int GW = ACCW - PW;

  // Widen by one bit so the signed multiplier covers unsigned operands too
  function automatic logic [PW-1:0] raw_product(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                                                input logic as, input logic bs);
    logic signed [OPW:0]     ax;
    logic signed [OPW:0]     bx;
    logic signed [2*OPW+1:0] full;
    ax   = {as & a[OPW-1], a};
    bx   = {bs & b[OPW-1], b};
    full = ax * bx;
    return full[PW-1:0];
  endfunction

  function automatic logic [ACCW-1:0] widen(input logic [PW-1:0] p, input logic any_sgn);
    return any_sgn ? {{GW{p[PW-1]}}, p} : {{GW{1'b0}}, p};
  endfunction

  logic [PW-1:0]   prod_raw;
  logic [ACCW-1:0] prod_ext;

  always_comb begin
    prod_raw = raw_product(a_i, b_i, a_sgn_i, b_sgn_i);
    prod_ext = widen(prod_raw, a_sgn_i | b_sgn_i);
    prod_o   = int_i ? prod_ext : {prod_ext[ACCW-2:0], 1'b0};
  end
endmodule

// File: rtl/mac40_combine.sv
module mac40_combine
  import mac40_pkg::*;
#(
  parameter int ACCW = 40
) (
  input  mac_op_e         op_i,
  input  logic [ACCW-1:0] acc_i,
  input  logic [ACCW-1:0] prod_i,
  output logic [ACCW-1:0] res_o
);
  function automatic logic [ACCW-1:0] combine(input mac_op_e op, input logic [ACCW-1:0] acc,
                                              input logic [ACCW-1:0] p);
    case (op)
      MOP_ADD: return acc + p;
      MOP_SUB: return acc - p;
      default: return p;
    endcase
  endfunction

  assign res_o = combine(op_i, acc_i, prod_i);
endmodule

// File: rtl/mac40_regs.sv
module mac40_regs #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_acc_i,
  input  logic            wr_fb_i,
  input  logic [ACCW-1:0] res_i,
  input  logic            ld_en_i,
  input  logic [1:0]      ld_sel_i,
  input  logic [OPW-1:0]  ld_data_i,
  output logic [ACCW-1:0] acc_o,
  output logic [OPW-1:0]  fb_o
);
  localparam int HIW = ACCW - 2 * OPW;

  logic [ACCW-1:0] acc_q;
  logic [OPW-1:0]  fb_q;
  logic            ld_live;

  // A load only lands when no accumulator write claims this cycle
  assign ld_live = ld_en_i & ~wr_acc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (wr_acc_i) begin
      acc_q <= res_i;
    end else if (ld_live) begin
      case (ld_sel_i)
        2'd0:    acc_q[OPW-1:0]      <= ld_data_i;
        2'd1:    acc_q[2*OPW-1:OPW]  <= ld_data_i;
        2'd2:    acc_q[ACCW-1:2*OPW] <= ld_data_i[HIW-1:0];
        default: acc_q               <= acc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fb_q <= '0;
    else if (wr_fb_i) fb_q <= res_i[2*OPW-1:OPW];
  end

  assign acc_o = acc_q;
  assign fb_o  = fb_q;

  a_r8_low_load_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_live && ld_sel_i == 2'd0) |=> ($stable(acc_q[ACCW-1:OPW]) && acc_q[OPW-1:0] == $past(ld_data_i)));

  a_r8_sel3_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_live && ld_sel_i == 2'd3) |=> $stable(acc_q));

  a_r9_op_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc_i && ld_en_i) |=> acc_q == $past(res_i));
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  localparam int HIW = ACCW - 2 * OPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_sel,
  input  logic [OPW-1:0]  a_in,
  input  logic [OPW-1:0]  b_in,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            int_mode,
  input  logic            to_fb,
  input  logic            ld_en,
  input  logic [1:0]      ld_sel,
  input  logic [OPW-1:0]  ld_data,
  output logic [OPW-1:0]  acc_lo,
  output logic [OPW-1:0]  acc_mid,
  output logic [HIW-1:0]  acc_hi,
  output logic [OPW-1:0]  fb_out
);
  logic [ACCW-1:0] prod_w;
  logic [ACCW-1:0] res_w;
  logic [ACCW-1:0] acc_w;
  logic            wr_acc_w;
  logic            wr_fb_w;
  mac_op_e         op_w;

  assign op_w     = mac_op_e'(op_sel);
  assign wr_acc_w = op_valid & ~to_fb;
  assign wr_fb_w  = op_valid & to_fb;

  mac40_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
    .a_i(a_in), .b_i(b_in), .a_sgn_i(a_signed), .b_sgn_i(b_signed),
    .int_i(int_mode), .prod_o(prod_w)
  );

  mac40_combine #(.ACCW(ACCW)) u_comb (
    .op_i(op_w), .acc_i(acc_w), .prod_i(prod_w), .res_o(res_w)
  );

  mac40_regs #(.OPW(OPW), .ACCW(ACCW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_acc_i(wr_acc_w), .wr_fb_i(wr_fb_w), .res_i(res_w),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .acc_o(acc_w), .fb_o(fb_out)
  );

  assign acc_lo  = acc_w[OPW-1:0];
  assign acc_mid = acc_w[2*OPW-1:OPW];
  assign acc_hi  = acc_w[ACCW-1:2*OPW];

  a_r2_frac_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !int_mode) |-> prod_w[0] == 1'b0);

  a_r1_unsigned_guard_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && int_mode && !a_signed && !b_signed) |-> prod_w[ACCW-1:2*OPW] == '0);

  a_r3_mul_discards_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc_w && (op_sel == 2'b00 || op_sel == 2'b11)) |=> acc_w == $past(prod_w));

  a_r6_fb_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fb_w) |=> $stable(fb_out));

  a_r7_fb_gets_mid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fb_w |=> fb_out == $past(res_w[2*OPW-1:OPW]));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !ld_en) |=> $stable(acc_w));
endmodule

// File: tb/mac40_unit_tb.sv
module mac40_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic        a_signed = 1'b0;
  logic        b_signed = 1'b0;
  logic        int_mode = 1'b0;
  logic        to_fb = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'b00;
  logic [15:0] ld_data = '0;
  logic [15:0] acc_lo, acc_mid, fb_out;
  logic [7:0]  acc_hi;

  int checks = 0;
  int errors = 0;
  logic [39:0] m_acc = '0;
  logic [15:0] m_fb  = '0;

  always #2 clk = ~clk;

  mac40_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .a_in(a_in), .b_in(b_in),
    .a_signed(a_signed), .b_signed(b_signed), .int_mode(int_mode), .to_fb(to_fb),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .acc_lo(acc_lo), .acc_mid(acc_mid), .acc_hi(acc_hi), .fb_out(fb_out)
  );

  // Exact integer product, reduced modulo 2^40, then scaled for fractional mode
  function automatic logic [39:0] exp_prod(input logic [15:0] a, input logic [15:0] b,
                                           input logic as, input logic bs, input logic im);
    longint av, bv, pv;
    logic [39:0] t;
    av = as ? longint'($signed(a)) : longint'(a);
    bv = bs ? longint'($signed(b)) : longint'(b);
    pv = av * bv;
    t  = pv[39:0];
    return im ? t : (t << 1);
  endfunction

  task automatic check(input string req);
    logic [39:0] got;
    got = {acc_hi, acc_mid, acc_lo};
    checks++;
    if (got !== m_acc || fb_out !== m_fb) begin
      errors++;
      $display("FAIL %s acc=%h fb=%h expected acc=%h fb=%h", req, got, fb_out, m_acc, m_fb);
    end
  endtask

  task automatic cyc(input logic v, input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                     input logic as, input logic bs, input logic im, input logic fb,
                     input logic le, input logic [1:0] ls, input logic [15:0] ld,
                     input string req);
    logic [39:0] p, r;
    op_valid = v; op_sel = op; a_in = a; b_in = b; a_signed = as; b_signed = bs;
    int_mode = im; to_fb = fb; ld_en = le; ld_sel = ls; ld_data = ld;
    @(posedge clk);
    p = exp_prod(a, b, as, bs, im);
    if (op == 2'b01)      r = m_acc + p;
    else if (op == 2'b10) r = m_acc - p;
    else                  r = p;
    if (v && !fb) m_acc = r;
    else if (le) begin
      if (ls == 2'd0)      m_acc[15:0]  = ld;
      else if (ls == 2'd1) m_acc[31:16] = ld;
      else if (ls == 2'd2) m_acc[39:32] = ld[7:0];
    end
    if (v && fb) m_fb = r[31:16];
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    @(negedge clk); @(negedge clk);
    check("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R10 idle hold
    cyc(0, 2'b01, 16'h1234, 16'h5678, 1, 1, 1, 0, 0, 0, 0, "R10 idle");
    // R1 mixed sign, integer
    cyc(1, 2'b00, 16'h8000, 16'hFFFF, 1, 0, 1, 0, 0, 0, 0, "R1 signed*unsigned");
    cyc(1, 2'b00, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, 0, 0, "R1 unsigned*unsigned");
    cyc(1, 2'b00, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0, 0, 0, 0, "R1 signed*signed");
    // R2 fractional vs integer
    cyc(1, 2'b00, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, 0, 0, "R2 fractional shift");
    cyc(1, 2'b00, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, 0, 0, "R2 integer no shift");
    cyc(1, 2'b00, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, "R2 unsigned fractional");
    // R4 accumulate, R5 subtract below zero, R3 op 11
    cyc(1, 2'b01, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, 0, 0, "R4 add");
    cyc(1, 2'b01, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0, 0, 0, "R4 add again");
    cyc(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, "R5 subtract");
    cyc(1, 2'b10, 16'h0001, 16'h0001, 0, 0, 1, 0, 0, 0, 0, "R5 subtract more");
    cyc(1, 2'b11, 16'h0003, 16'h0005, 0, 0, 1, 0, 0, 0, 0, "R3 op 11 multiply");
    cyc(1, 2'b00, 16'h0100, 16'h0100, 0, 0, 1, 0, 0, 0, 0, "R3 multiply replaces");
    // R6 / R7 destinations
    cyc(1, 2'b01, 16'h1234, 16'h4321, 0, 0, 0, 1, 0, 0, 0, "R7 to feedback");
    cyc(1, 2'b01, 16'h0ABC, 16'h0002, 0, 0, 1, 0, 0, 0, 0, "R6 to accumulator");
    // R8 section loads
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 2'd0, 16'hA1A2, "R8 load low");
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 2'd1, 16'hB1B2, "R8 load mid");
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hC1C2, "R8 load guard");
    cyc(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, 2'd3, 16'hDDDD, "R8 sel3 ignored");
    // R9 collisions
    cyc(1, 2'b01, 16'h0010, 16'h0010, 0, 0, 1, 0, 1, 2'd1, 16'h5555, "R9 op to acc wins");
    cyc(1, 2'b01, 16'h0001, 16'h0000, 0, 0, 1, 1, 1, 2'd1, 16'h7777, "R9 fb uses pre-load acc");
    for (int i = 0; i < 600; i++) begin
      logic v, fb, le;
      logic [1:0] op, ls;
      string tag;
      v = ($urandom % 4) != 0;
      fb = ($urandom % 3) == 0;
      le = ($urandom % 4) == 0;
      op = 2'($urandom);
      ls = 2'($urandom);
      if (v && le)        tag = "R9 random collision";
      else if (v && fb)   tag = "R7 random";
      else if (le)        tag = "R8 random";
      else if (!v)        tag = "R10 random idle";
      else if (op == 2'b01) tag = "R4 random";
      else if (op == 2'b10) tag = "R5 random";
      else                tag = "R3 random";
      cyc(v, op, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          fb, le, ls, 16'($urandom), tag);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule